// File: doc/BRIEF.md
# Sequential Double-LSB Multiplier

This block multiplies two operands held in double-LSB form. Each operand is a k-bit core plus one extra bit that carries the same weight as the core's least significant bit, so its value is core + extra. In signed mode the core is read as two's complement. The extra bit makes the range symmetric, and it gives zero two codes: all zeros with extra 0, and all ones with extra 1. In unsigned mode the operand range is [0, 2^k].

A one-cycle `start` captures both operands and the mode. The block then works one multiplier bit per cycle in a right-shifting accumulator. The multiplicand's extra bit never gets its own add. It enters every accumulation as the adder's carry-in, or as the inverted carry-in when the top-bit term is subtracted in signed mode. The multiplier's extra bit decides the accumulator's starting value, which is either zero or the full multiplicand. The result is a 2k-bit core plus an extra bit. The extra bit is set only for the unsigned maximum 2^(2k), which cannot fit in the core.

Top module: `dlsb_mul`

## Requirements
- R1: In unsigned mode, the result core equals (y+Y0)·(x+X0) as a 2k-bit unsigned number, with `prodExtra` 0, for every product below 2^(2k).
- R2: In unsigned mode, all-ones cores with both extra bits set give the product 2^(2k). This is output as an all-ones core with `prodExtra` 1.
- R3: In signed mode, the result core is the 2k-bit two's-complement encoding of (y+Y0)·(x+X0), where each core is read as signed, and `prodExtra` is 0.
- R4: In signed mode, either zero code (all-zero core with extra 0, or all-ones core with extra 1) on either operand gives an all-zero result core.
- R5: `prodExtra` is 1 only for an unsigned operation whose result core is all ones.
- R6: `done` is high for exactly one cycle. It rises k+1 clock edges after the edge that accepts `start`.
- R7: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `busy` and `done` are never high together.
- R8: `start` is ignored while `busy` is high. The result reflects only the operands captured at acceptance, and the result outputs hold their previous value until `done`.
- R9: While reset is held and after it, before any start, `busy`, `done`, `prodCore` and `prodExtra` are all zero.
- R10: In signed mode, operands at the symmetric extremes (±2^(k-1)) give exact products of ±2^(2k-2) with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply; accepted only when idle |
| signedMode | input | 1 | 1: two's-complement cores, 0: unsigned cores |
| mcandCore | input | K | Multiplicand core y |
| mcandExtra | input | 1 | Multiplicand extra LSB Y0 |
| mplrCore | input | K | Multiplier core x |
| mplrExtra | input | 1 | Multiplier extra LSB X0 |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| prodCore | output | 2K | Product core |
| prodExtra | output | 1 | Product extra LSB |

## Verification
The assertions assume that reset is held low for at least one clock edge. They also assume that `start`, `signedMode` and the operand inputs hold known values at every edge. The checker records the mode at the edge that accepts `start`, and the flag and latency properties are judged against that stored mode. The stimulus changes inputs only at falling clock edges and holds reset for several cycles. It also raises `start` during a run with changed operands, so the rule that only accepted operands count is exercised against the bench's own integer products.

// File: rtl/dlsb_mul_pkg.sv
package dlsb_mul_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch operands and mode
    logic load;     // initialise accumulator from the multiplier extra bit
    logic step;     // one add-and-shift cycle
    logic last;     // the step for the multiplier's top core bit
  } mulStrobe_t;

endpackage

// File: rtl/dlsb_mul_ctrl.sv
module dlsb_mul_ctrl
  import dlsb_mul_pkg::*;
#(
  parameter int K = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CW = (K > 2) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(K - 1);

  typedef enum logic [1:0] { ST_IDLE, ST_LOAD, ST_RUN } ctrlState_t;

  ctrlState_t state;
  logic [CW-1:0] bitIdx;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && start;
    strobe.load    = (state == ST_LOAD);
    strobe.step    = (state == ST_RUN);
    strobe.last    = (state == ST_RUN) && (bitIdx == LAST_IDX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_LOAD;
        ST_LOAD: begin
          bitIdx <= '0;
          state  <= ST_RUN;
        end
        ST_RUN: begin
          if (bitIdx == LAST_IDX) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dlsb_mul_dp.sv
module dlsb_mul_dp
  import dlsb_mul_pkg::*;
#(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  mulStrobe_t     strobe,
  input  logic           signedMode,
  input  logic [K-1:0]   mcandCore,
  input  logic           mcandExtra,
  input  logic [K-1:0]   mplrCore,
  input  logic           mplrExtra,
  output logic [2*K-1:0] prodCore,
  output logic           prodExtra
);

  localparam int AW = K + 2;   // accumulator holds sums up to twice the multiplicand
  localparam int PW = 2 * K;

  logic [K-1:0]  mcReg;
  logic          mcxReg;
  logic          mpxReg;
  logic          sgnReg;
  logic [AW-1:0] acc;
  logic [K-1:0]  lowBits;   // multiplier bits shift out, product bits shift in

  logic [AW-1:0] extY, addBase, addend, sum, nextAcc;
  logic [K-1:0]  nextLow;
  logic          useTerm, subTerm, carryIn, fill, atMax;

  always_comb begin
    extY    = sgnReg ? {{2{mcReg[K-1]}}, mcReg} : {2'b00, mcReg};
    useTerm = strobe.load ? mpxReg : lowBits[0];
    subTerm = strobe.last && sgnReg;
    addBase = strobe.load ? '0 : acc;
    // y + Y0 is formed with Y0 as carry-in; its negation is ~y + ~Y0
    addend  = useTerm ? (subTerm ? ~extY : extY) : '0;
    carryIn = useTerm && (subTerm ? !mcxReg : mcxReg);
    sum     = addBase + addend + AW'(carryIn);
    fill    = sgnReg & sum[AW-1];
    nextAcc = {fill, sum[AW-1:1]};
    nextLow = {sum[0], lowBits[K-1:1]};
    atMax   = !sgnReg && nextAcc[K];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcReg     <= '0;
      mcxReg    <= 1'b0;
      mpxReg    <= 1'b0;
      sgnReg    <= 1'b0;
      acc       <= '0;
      lowBits   <= '0;
      prodCore  <= '0;
      prodExtra <= 1'b0;
    end else begin
      if (strobe.capture) begin
        mcReg   <= mcandCore;
        mcxReg  <= mcandExtra;
        mpxReg  <= mplrExtra;
        sgnReg  <= signedMode;
        lowBits <= mplrCore;
      end
      if (strobe.load) acc <= sum;
      if (strobe.step) begin
        acc     <= nextAcc;
        lowBits <= nextLow;
        if (strobe.last) begin
          prodCore  <= atMax ? {PW{1'b1}} : {nextAcc[K-1:0], nextLow};
          prodExtra <= atMax;
        end
      end
    end
  end

endmodule

// File: rtl/dlsb_mul.sv
module dlsb_mul
  import dlsb_mul_pkg::*;
#(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           signedMode,
  input  logic [K-1:0]   mcandCore,
  input  logic           mcandExtra,
  input  logic [K-1:0]   mplrCore,
  input  logic           mplrExtra,
  output logic           busy,
  output logic           done,
  output logic [2*K-1:0] prodCore,
  output logic           prodExtra
);

  mulStrobe_t strobe;

  dlsb_mul_ctrl #(.K(K)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  dlsb_mul_dp #(.K(K)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .signedMode (signedMode),
    .mcandCore  (mcandCore),
    .mcandExtra (mcandExtra),
    .mplrCore   (mplrCore),
    .mplrExtra  (mplrExtra),
    .prodCore   (prodCore),
    .prodExtra  (prodExtra)
  );

endmodule

// File: rtl/dlsb_mul_chk.sv
module dlsb_mul_chk #(
  parameter int K = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           signedMode,
  input logic           busy,
  input logic           done,
  input logic [2*K-1:0] prodCore,
  input logic           prodExtra
);

  localparam int CW = $clog2(K + 2) + 1;

  logic [CW-1:0] runCnt;
  logic          sgnCap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
      sgnCap <= 1'b0;
    end else if (start && !busy) begin
      runCnt <= '0;
      sgnCap <= signedMode;
    end else if (busy) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done arrives k+1 edges after acceptance
  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == CW'(K + 1)));

  // R7: busy and done never overlap
  p_busy_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7: acceptance raises busy
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R8: result outputs hold until done
  p_prod_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(prodCore) && $stable(prodExtra)));

  // R5: extra bit only with an all-ones core in unsigned mode
  p_extra_max_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && prodExtra) |-> ((&prodCore) && !sgnCap));

  // R3: signed results never set the extra bit
  p_signed_extra_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && sgnCap) |-> !prodExtra);

endmodule

bind dlsb_mul dlsb_mul_chk #(.K(K)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .signedMode (signedMode),
  .busy       (busy),
  .done       (done),
  .prodCore   (prodCore),
  .prodExtra  (prodExtra)
);

// File: tb/dlsb_mul_tb_top.sv
`timescale 1ns/1ps
module dlsb_mul_tb_top;

  localparam int K  = 8;
  localparam int PW = 2 * K;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          signedMode = 1'b0;
  logic [K-1:0]  mcandCore = '0;
  logic          mcandExtra = 1'b0;
  logic [K-1:0]  mplrCore = '0;
  logic          mplrExtra = 1'b0;
  logic          busy, done;
  logic [PW-1:0] prodCore;
  logic          prodExtra;

  int testCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;

  dlsb_mul #(.K(K)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .mcandCore(mcandCore), .mcandExtra(mcandExtra),
    .mplrCore(mplrCore), .mplrExtra(mplrExtra),
    .busy(busy), .done(done), .prodCore(prodCore), .prodExtra(prodExtra)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint dlsbVal(input bit sgn, input logic [K-1:0] c, input bit e);
    longint v;
    v = sgn ? longint'($signed(c)) : longint'(c);
    return v + longint'(e);
  endfunction

  task automatic runMul(input bit sgn, input logic [K-1:0] y, input bit yx,
                        input logic [K-1:0] x, input bit xx,
                        input string tag, input bit disturb);
    longint p;
    logic [PW-1:0] expCore, prevCore;
    bit expExtra;
    int lat;
    p = dlsbVal(sgn, y, yx) * dlsbVal(sgn, x, xx);
    if (!sgn && p == (64'sd1 <<< PW)) begin
      expCore = '1; expExtra = 1'b1;
    end else begin
      expCore = PW'(p); expExtra = 1'b0;
    end
    prevCore = prodCore;
    @(negedge clk);
    signedMode = sgn; mcandCore = y; mcandExtra = yx;
    mplrCore = x; mplrExtra = xx; start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R7", "busy after accept", longint'(busy), 1);
    lat = 0;
    if (disturb) begin
      signedMode = ~sgn; mcandCore = ~y; mcandExtra = ~yx;
      mplrCore = K'($urandom); mplrExtra = ~xx;
      check(prodCore == prevCore, "R8", "result held during run",
            longint'(prodCore), longint'(prevCore));
      @(negedge clk); lat++;
      @(negedge clk); lat++;
    end
    start = 1'b0;
    while (!done && lat < 4 * K + 8) begin
      @(negedge clk);
      lat++;
    end
    check(lat == K + 1, "R6", "done latency", lat, K + 1);
    check(prodCore == expCore, tag, "product core", longint'(prodCore), longint'(expCore));
    check(prodExtra == expExtra, tag, "product extra", longint'(prodExtra), longint'(expExtra));
    check(!busy, "R7", "busy low with done", longint'(busy), 0);
    @(negedge clk);
    check(!done, "R6", "done one cycle", longint'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !done, "R9", "control idle in reset", longint'({busy, done}), 0);
    check(prodCore == '0 && !prodExtra, "R9", "result zero in reset", longint'(prodCore), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R9", "control idle after reset", longint'({busy, done}), 0);
    check(prodCore == '0 && !prodExtra, "R9", "result zero after reset", longint'(prodCore), 0);

    // R1 directed
    runMul(1'b0, K'(13), 1'b0, K'(11), 1'b0, "R1", 1'b0);
    runMul(1'b0, K'(13), 1'b1, K'(11), 1'b1, "R1", 1'b0);
    runMul(1'b0, '1, 1'b0, '1, 1'b1, "R1", 1'b0);
    // R2 unsigned maximum
    runMul(1'b0, '1, 1'b1, '1, 1'b1, "R2", 1'b0);
    // R3 directed signed
    runMul(1'b1, K'(-5), 1'b0, K'(7), 1'b1, "R3", 1'b0);
    runMul(1'b1, K'(-5), 1'b1, K'(-3), 1'b0, "R3", 1'b0);
    // R4 both zero codes on each side
    runMul(1'b1, '1, 1'b1, K'(-77), 1'b1, "R4", 1'b0);
    runMul(1'b1, K'(93), 1'b0, '1, 1'b1, "R4", 1'b0);
    runMul(1'b1, '0, 1'b0, '1, 1'b1, "R4", 1'b0);
    // R10 signed extremes
    runMul(1'b1, {1'b1, {(K-1){1'b0}}}, 1'b0, {1'b1, {(K-1){1'b0}}}, 1'b0, "R10", 1'b0);
    runMul(1'b1, {1'b0, {(K-1){1'b1}}}, 1'b1, {1'b1, {(K-1){1'b0}}}, 1'b0, "R10", 1'b0);
    runMul(1'b1, {1'b0, {(K-1){1'b1}}}, 1'b1, {1'b0, {(K-1){1'b1}}}, 1'b1, "R10", 1'b0);
    // R5: all-ones core in signed mode keeps extra bit clear
    runMul(1'b1, '1, 1'b0, K'(1), 1'b0, "R5", 1'b0);
    // R8 start pulses with new operands while busy
    runMul(1'b0, K'(200), 1'b1, K'(37), 1'b0, "R8", 1'b1);
    runMul(1'b1, K'(-100), 1'b0, K'(55), 1'b1, "R8", 1'b1);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      bit sgn;
      sgn = 1'($urandom);
      runMul(sgn, K'($urandom), 1'($urandom), K'($urandom), 1'($urandom),
             sgn ? "R3" : "R1", (i % 37) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule